// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the front end of a transmit DMA path. Software builds a ring of two-word descriptors in a word-wide memory. Each descriptor holds a buffer byte address and a control word. Software then writes the ring start address and issues a go command. The engine walks the ring one descriptor at a time. It reads each referenced buffer one byte per memory read and presents the bytes on a ready/valid byte stream. The first byte of a frame is marked as frame start, and the final byte of the closing buffer is marked as frame end.

When the closing buffer of a frame has been sent, the engine writes the control word of the frame's first descriptor back with the ownership bit set. It also raises a sticky done flag, then carries on with the next descriptor. Fetching stops when it meets a descriptor that software still has to hand over. If that descriptor appears in the middle of a frame, or if the memory signals a read error on buffer data, the frame is aborted. The cause is then recorded in the first descriptor's control word.

Top module: `txd_fetch`

## Requirements
- R1: After reset the engine is idle: `busy_o` is 0, `stat_o` is 0, `tx_valid_o` is 0 and `mem_req_o` is 0.
- R2: A control write (`reg_sel_i`=0) stores bit 3 as the enable. The engine leaves idle only when a control write has both bit 9 and bit 3 set. A write with bit 9 set and bit 3 clear starts nothing.
- R3: A descriptor is the buffer byte address at pointer P, followed by a control word at P+4. In the control word, bits 10:0 are the byte count, bit 15 marks the closing buffer of a frame, bit 30 marks the final ring entry and bit 31 is the ownership (used) bit. The byte at address A is taken from memory word A>>2, bits 8*(A mod 4)+7 down to 8*(A mod 4). Bytes go out in rising address order.
- R4: `tx_sof_o` is high on the first byte of a frame and `tx_eof_o` on the last byte of its closing buffer. Buffers without bit 15 are concatenated into the same frame.
- R5: When a frame completes, the control word of its first descriptor is rewritten with bit 31 set and all other bits kept. After that write, stat_o bit 5 (done) is set and the next descriptor is fetched.
- R6: A used descriptor met at a frame boundary stops the engine with no memory write. A later go command resumes at that same descriptor.
- R7: After a descriptor with bit 30 set, the next descriptor is read at the ring start address. A base write (`reg_sel_i`=2, low 3 bits ignored) sets both the ring start and the current pointer.
- R8: A used descriptor met mid-frame aborts the frame. `tx_abort_o` pulses with no frame end, the first descriptor's control word gets bits 31 and 27 set, done stays clear, and the engine goes idle.
- R9: A memory error flag on a buffer-data read aborts the frame before that byte is sent. The first descriptor's control word gets bits 31 and 28 set, done stays clear, and the engine goes idle.
- R10: Writing the status register (`reg_sel_i`=1) with bit 5 set clears done. If done is being set in the same cycle, it stays set.
- R11: A go command issued while the engine is busy is ignored and does not disturb the frame in flight.
- R12: While `tx_valid_o` is high and `tx_ready_i` is low, the byte and the markers are held.
- R13: A descriptor with a byte count of zero emits nothing. It still joins the frame and its closing flag is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 ring base |
| reg_wdata_i | input | 32 | Register write data |
| stat_o | output | 32 | Status: bit 5 done, bit 3 active |
| busy_o | output | 1 | Engine not idle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (descriptor writeback) |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, one cycle after request |
| mem_err_i | input | 1 | Read error, aligned with read data |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Byte |
| tx_sof_o | output | 1 | Frame start marker |
| tx_eof_o | output | 1 | Frame end marker |
| tx_ready_i | input | 1 | Sink ready |
| tx_abort_o | output | 1 | Pulse on aborted frame |

## Verification
The engine setting the done flag and software clearing it with a write-one can land on the same clock edge. The bench provokes this by watching for the descriptor writeback strobe at the falling edge. It then drives the status clear write so that it is sampled on the very edge where done is set. It judges the collision by reading done as still 1 afterwards. A separate clear write on a quiet cycle is then checked to drop done to 0.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned USED_B = 31;
  localparam int unsigned WRAP_B = 30;
  localparam int unsigned UDR_B  = 28;
  localparam int unsigned EXH_B  = 27;
  localparam int unsigned LAST_B = 15;

  localparam int unsigned CTRL_EN_B = 3;
  localparam int unsigned CTRL_GO_B = 9;
  localparam int unsigned STAT_ACT_B  = 3;
  localparam int unsigned STAT_DONE_B = 5;

  localparam logic [31:0] USED_M = 32'd1 << USED_B;
  localparam logic [31:0] UDR_M  = 32'd1 << UDR_B;
  localparam logic [31:0] EXH_M  = 32'd1 << EXH_B;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DA, ST_DS, ST_DC, ST_BR, ST_BW, ST_OUT, ST_END_WB
  } unused_state_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DADR, S_DSTAT, S_DCHK, S_BREQ, S_BCAP, S_OUT, S_END, S_WB
  } seq_state_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [31:0]   wdata_i,
  input  logic          idle_i,
  input  logic          done_set_i,
  output logic          en_o,
  output logic          go_o,
  output logic          base_ld_o,
  output logic [AW-1:0] base_val_o,
  output logic          done_o
);
  logic en_q, done_q, clr;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[2:0];
  assign clr = we_i && sel_i == SEL_STAT && wdata_i[STAT_DONE_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (we_i && sel_i == SEL_CTRL) en_q <= wdata_i[CTRL_EN_B];
      if (done_set_i)  done_q <= 1'b1;   // set beats clear
      else if (clr)    done_q <= 1'b0;
    end
  end

  assign en_o       = en_q;
  assign done_o     = done_q;
  assign go_o       = we_i && sel_i == SEL_CTRL && wdata_i[CTRL_GO_B] &&
                      wdata_i[CTRL_EN_B] && idle_i;
  assign base_ld_o  = we_i && sel_i == SEL_BASE && idle_i;
  assign base_val_o = {wdata_i[AW-1:3], 3'b000};
endmodule

// File: rtl/txd_ptr.sv
module txd_ptr #(
  parameter int AW = 32,
  parameter int DW_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(DW_BYTES);
  logic [AW-1:0] base_q, ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (ld_i) begin
      base_q <= ld_val_i;
      ptr_q  <= ld_val_i;
    end else if (adv_i) begin
      ptr_q <= wrap_i ? base_q : ptr_q + STEP;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/txd_seq.sv
module txd_seq
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          en_i,
  input  logic [AW-1:0] ptr_i,
  output logic          adv_o,
  output logic          wrap_o,
  output logic          done_set_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_err_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_sof_o,
  output logic          tx_eof_o,
  input  logic          tx_ready_i,
  output logic          tx_abort_o
);
  localparam logic [AW-1:0] STAT_OFS = AW'(4);

  seq_state_e    st_q;
  logic [AW-1:0] buf_q, first_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] len;
  logic          last_q, wrap_q, infr_q, sof_q, err_q;
  logic [31:0]   fst_q, wb_q;
  logic [7:0]    byte_q;

  assign len = mem_rdata_i[LW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      buf_q <= '0; first_q <= '0; rem_q <= '0;
      last_q <= 1'b0; wrap_q <= 1'b0; infr_q <= 1'b0;
      sof_q <= 1'b0; err_q <= 1'b0;
      fst_q <= '0; wb_q <= '0; byte_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE:  if (go_i) st_q <= S_DADR;
        S_DADR:  st_q <= en_i ? S_DSTAT : S_IDLE;
        S_DSTAT: begin
          buf_q <= mem_rdata_i[AW-1:0];
          st_q  <= S_DCHK;
        end
        S_DCHK: begin
          if (mem_rdata_i[USED_B]) begin
            if (infr_q) begin
              wb_q  <= fst_q | USED_M | EXH_M;
              err_q <= 1'b1;
              st_q  <= S_WB;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            if (!infr_q) begin
              infr_q  <= 1'b1;
              sof_q   <= 1'b1;
              first_q <= ptr_i;
              fst_q   <= mem_rdata_i;
            end
            rem_q  <= len;
            last_q <= mem_rdata_i[LAST_B];
            wrap_q <= mem_rdata_i[WRAP_B];
            st_q   <= (len == '0) ? S_END : S_BREQ;
          end
        end
        S_BREQ: st_q <= S_BCAP;
        S_BCAP: begin
          if (mem_err_i) begin
            wb_q  <= fst_q | USED_M | UDR_M;
            err_q <= 1'b1;
            st_q  <= S_WB;
          end else begin
            byte_q <= mem_rdata_i[{buf_q[1:0], 3'b000} +: 8];
            st_q   <= S_OUT;
          end
        end
        S_OUT: if (tx_ready_i) begin
          sof_q <= 1'b0;
          rem_q <= rem_q - 1'b1;
          buf_q <= buf_q + 1'b1;
          st_q  <= (rem_q == LW'(1)) ? S_END : S_BREQ;
        end
        S_END: begin
          if (last_q) begin
            wb_q <= fst_q | USED_M;
            st_q <= S_WB;
          end else begin
            st_q <= S_DADR;
          end
        end
        S_WB: begin
          infr_q <= 1'b0;
          err_q  <= 1'b0;
          st_q   <= err_q ? S_IDLE : S_DADR;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign adv_o      = st_q == S_END;
  assign wrap_o     = wrap_q;
  assign done_set_o = st_q == S_WB && !err_q;
  assign busy_o     = st_q != S_IDLE;
  assign tx_abort_o = st_q == S_WB && err_q;

  assign mem_req_o   = st_q inside {S_DADR, S_DSTAT, S_BREQ, S_WB};
  assign mem_we_o    = st_q == S_WB;
  assign mem_wdata_o = wb_q;
  always_comb begin
    unique case (st_q)
      S_DSTAT: mem_addr_o = ptr_i + STAT_OFS;
      S_BREQ:  mem_addr_o = {buf_q[AW-1:2], 2'b00};
      S_WB:    mem_addr_o = first_q + STAT_OFS;
      default: mem_addr_o = ptr_i;
    endcase
  end

  assign tx_valid_o = st_q == S_OUT;
  assign tx_data_o  = byte_q;
  assign tx_sof_o   = st_q == S_OUT && sof_q;
  assign tx_eof_o   = st_q == S_OUT && last_q && rem_q == LW'(1);

  // R12
  hold_under_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) &&
                                     $stable(tx_sof_o) && $stable(tx_eof_o)));
  // R8
  abort_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> (!tx_valid_o && mem_we_o));
endmodule

// File: rtl/txd_fetch.sv
module txd_fetch
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   stat_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_err_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_sof_o,
  output logic          tx_eof_o,
  input  logic          tx_ready_i,
  output logic          tx_abort_o
);
  logic          en, go, base_ld, done, done_set, adv, wrap, busy;
  logic [AW-1:0] base_val, ptr;

  txd_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .idle_i(!busy), .done_set_i(done_set),
    .en_o(en), .go_o(go), .base_ld_o(base_ld), .base_val_o(base_val),
    .done_o(done)
  );

  txd_ptr #(.AW(AW), .DW_BYTES(8)) u_ptr (
    .clk_i, .rst_ni,
    .ld_i(base_ld), .ld_val_i(base_val),
    .adv_i(adv), .wrap_i(wrap), .ptr_o(ptr)
  );

  txd_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk_i, .rst_ni,
    .go_i(go), .en_i(en), .ptr_i(ptr),
    .adv_o(adv), .wrap_o(wrap), .done_set_o(done_set), .busy_o(busy),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_err_i,
    .tx_valid_o, .tx_data_o, .tx_sof_o, .tx_eof_o, .tx_ready_i, .tx_abort_o
  );

  always_comb begin
    stat_o = '0;
    stat_o[STAT_DONE_B] = done;
    stat_o[STAT_ACT_B]  = busy;
  end
  assign busy_o = busy;

  // R2
  go_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i && reg_sel_i == SEL_CTRL &&
                            reg_wdata_i[CTRL_GO_B] && reg_wdata_i[CTRL_EN_B]));
  // R5
  done_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[STAT_DONE_B]) |-> $past(mem_we_o));
  // R5
  wb_sets_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[USED_B]);
endmodule

// File: tb/txd_fetch_test.sv
module txd_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] stat;
  logic        busy, mem_req, mem_we, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_sof, tx_eof, tx_ready, tx_abort;
  logic [7:0]  tx_data;

  logic [31:0] mem [0:255];
  logic [7:0]  err_word = 8'hff;
  logic        bp = 1'b0;
  logic [1:0]  cyc = '0;
  logic [9:0]  exp_q [$];
  int          n_chk = 0, n_fail = 0, n_abort = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  txd_fetch uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .stat_o(stat), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_sof_o(tx_sof),
    .tx_eof_o(tx_eof), .tx_ready_i(tx_ready), .tx_abort_o(tx_abort)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[9:2]];
        mem_err   <= mem_addr[9:2] == err_word;
      end
    end else mem_err <= 1'b0;
  end
  assign tx_ready = !bp || cyc != 2'd1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (tx_abort) n_abort++;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", {22'd0, tx_sof, tx_eof, tx_data}, 32'd0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({tx_sof, tx_eof, tx_data} == e, "R3/R4 stream byte",
            {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, e});
      end
    end
  end

  function automatic logic [7:0] byte_at(input logic [9:0] a);
    return mem[a[9:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic push_buf(input logic [9:0] a, input int len, input bit sof, input bit eof);
    for (int k = 0; k < len; k++)
      exp_q.push_back({sof && k == 0, eof && k == len - 1, byte_at(a + 10'(k))});
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic collide();
    @(negedge clk);
    while (!mem_we) @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h20;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic put_desc(input logic [9:0] p, input logic [31:0] a, input logic [31:0] s);
    mem[p[9:2]] = a;
    mem[p[9:2] + 8'd1] = s;
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {8'(i * 7 + 3), 8'(i * 5 + 1), 8'(i * 3 + 2), 8'(i + 9)};
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && stat == 0 && !tx_valid && !mem_req, "R1 reset state",
        {stat[31:3], busy, tx_valid, mem_req}, 0);
    rst_n = 1'b1;

    // R2: go without enable
    reg_wr(2'd0, 32'h200);
    repeat (5) @(negedge clk);
    chk(!busy, "R2 go without enable", busy, 0);

    // R3 R4 R5 R10 R11 R12: two-buffer frame under backpressure
    put_desc(10'h100, 32'h201, 32'h3);
    put_desc(10'h108, 32'h300, 32'h8005);
    put_desc(10'h110, 32'h0, 32'h8000_0000);
    reg_wr(2'd2, 32'h100);
    push_buf(10'h201, 3, 1'b1, 1'b0);
    push_buf(10'h300, 5, 1'b0, 1'b1);
    bp = 1'b1;
    reg_wr(2'd0, 32'h208);
    repeat (6) @(negedge clk);
    reg_wr(2'd0, 32'h208);               // R11 ignored while busy
    collide();                           // R10 set and clear together
    wait_idle();
    bp = 1'b0;
    drained("R11 frame intact");
    chk(mem[8'h41] == 32'h8000_0003, "R5 first desc writeback", mem[8'h41], 32'h8000_0003);
    chk(mem[8'h43] == 32'h8005, "R5 second desc untouched", mem[8'h43], 32'h8005);
    chk(stat[5], "R10 set wins over clear", stat, 32'h20);
    reg_wr(2'd1, 32'h20);
    chk(!stat[5], "R10 write-one clears done", stat, 0);

    // R6 resume at stopping descriptor; R7 wrap to base
    put_desc(10'h110, 32'h310, 32'h4000_8002);
    push_buf(10'h310, 2, 1'b1, 1'b1);
    reg_wr(2'd0, 32'h208);
    wait_idle();
    drained("R6 resume at stop point");
    chk(mem[8'h45] == 32'hC000_8002, "R6 resumed desc writeback", mem[8'h45], 32'hC000_8002);
    chk(mem[8'h41] == 32'h8000_0003, "R6 stop writes nothing", mem[8'h41], 32'h8000_0003);
    chk(stat[5], "R5 done after frame", stat, 32'h20);
    reg_wr(2'd1, 32'h20);
    put_desc(10'h100, 32'h320, 32'h8001);
    put_desc(10'h108, 32'h0, 32'h8000_0000);
    push_buf(10'h320, 1, 1'b1, 1'b1);
    reg_wr(2'd0, 32'h208);
    wait_idle();
    drained("R7 wrap to ring base");
    chk(mem[8'h41] == 32'h8000_8001, "R7 base desc writeback", mem[8'h41], 32'h8000_8001);

    // R8 exhausted mid-frame
    reg_wr(2'd1, 32'h20);
    put_desc(10'h180, 32'h330, 32'h2);
    put_desc(10'h188, 32'h0, 32'h8000_8000);
    reg_wr(2'd2, 32'h180);
    push_buf(10'h330, 2, 1'b1, 1'b0);
    reg_wr(2'd0, 32'h208);
    wait_idle();
    drained("R8 bytes before abort");
    chk(n_abort == 1, "R8 abort pulse", n_abort, 1);
    chk(mem[8'h61] == 32'h8800_0002, "R8 exhausted flags", mem[8'h61], 32'h8800_0002);
    chk(!stat[5] && !busy, "R8 no done, idle", stat, 0);

    // R9 underrun on second byte
    put_desc(10'h1A0, 32'h343, 32'h8003);
    reg_wr(2'd2, 32'h1A0);
    err_word = 8'hD1;
    push_buf(10'h343, 1, 1'b1, 1'b0);
    reg_wr(2'd0, 32'h208);
    wait_idle();
    err_word = 8'hff;
    drained("R9 bytes before abort");
    chk(n_abort == 2, "R9 abort pulse", n_abort, 2);
    chk(mem[8'h69] == 32'h9000_8003, "R9 underrun flags", mem[8'h69], 32'h9000_8003);
    chk(!stat[5] && !busy, "R9 no done, idle", stat, 0);

    // R13 zero-length buffer
    put_desc(10'h1C0, 32'h350, 32'h0);
    put_desc(10'h1C8, 32'h360, 32'h8002);
    put_desc(10'h1D0, 32'h0, 32'h8000_0000);
    reg_wr(2'd2, 32'h1C0);
    push_buf(10'h360, 2, 1'b1, 1'b1);
    reg_wr(2'd0, 32'h208);
    wait_idle();
    drained("R13 empty buffer skipped");
    chk(mem[8'h71] == 32'h8000_0000, "R13 empty first desc writeback", mem[8'h71], 32'h8000_0000);
    chk(stat[5], "R13 done set", stat, 32'h20);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule